// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block holds the 32-bit instruction address of a single-cycle processor and picks the address of the next instruction on every clock edge. Instructions are one word long, so the address always advances in steps of four bytes and its two low bits are always zero. There is no write enable. The register takes a new value at every edge.

The decode stage drives five inputs: a branch request, the zero flag from the ALU compare, a jump request, a 16-bit signed word offset and a 26-bit jump field. One of three sources is picked for the next address:

- **SRC_SEQ** is the address after the current one.
- **SRC_BRANCH** is the address after the current one plus the offset scaled to bytes. It is picked only when the branch request and the zero flag are both set.
- **SRC_JUMP** keeps the 4-bit region of the incremented address, then the jump field, then two zero bits. It is picked whenever a jump is requested, whatever the branch inputs are.

The transitions of the source selector are as follows. A jump request leads to SRC_JUMP. Otherwise a branch request together with a set zero flag leads to SRC_BRANCH. Every other case leads to SRC_SEQ. A synchronous active-high reset loads a word-aligned start address, which is a parameter.

Top module: `pc_next_unit`

## Requirements
- R1: At a clock edge where `rst` is 1, `pc` becomes RESET_VEC (default 0), whatever the other inputs are.
- R2: `pc_plus4` always equals `pc` + 4, taken modulo 2^32.
- R3: With `jump_req` at 0 and `branch_req` at 0, the next `pc` is `pc` + 4.
- R4: With `jump_req` at 0, `branch_req` at 1 and `alu_zero` at 1, the next `pc` is `pc` + 4 + (sign-extended `br_offset` × 4). `br_offset` is a two's-complement word count, so 16'hFFFE moves back two words from `pc` + 4.
- R5: If only one of `branch_req` and `alu_zero` is 1 and `jump_req` is 0, the branch has no effect and the next `pc` is `pc` + 4.
- R6: With `jump_req` at 1, the next `pc` is {(`pc`+4)[31:28], `jump_field`[25:0], 2'b00}.
- R7: When `jump_req`, `branch_req` and `alu_zero` are all 1, the jump target of R6 is taken and not the branch target.
- R8: `pc`[1:0] is 0 in every cycle.
- R9: Address arithmetic wraps modulo 2^32. 32'hFFFFFFFC followed by a sequential step gives 0. A jump taken at 32'h0FFFFFFC takes its region bits from 32'h10000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the register updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset to RESET_VEC |
| branch_req | input | 1 | Conditional branch requested by decode |
| alu_zero | input | 1 | Zero flag of the ALU compare |
| jump_req | input | 1 | Unconditional jump requested by decode |
| br_offset | input | 16 | Signed branch offset in words |
| jump_field | input | 26 | Word address field of a jump |
| pc | output | 32 | Current instruction address |
| pc_plus4 | output | 32 | Current address plus four |

## Verification
Assertions check the following on every clock cycle after reset:
- the low address bits stay zero;
- each of the three transfer rules holds, compared against the value the address and the inputs had one cycle earlier;
- the jump wins when both requests are set.

What the assertions cannot show is the absolute start value after reset, and the effect of a reset that arrives while a jump is requested. Those come from the bench's scenarios. The bench's scenarios also cover the modulo wrap at the top of the address space, a jump whose region bits change because the incremented address crosses a 256 MB boundary, and the most negative branch offset.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    // Source of the next instruction address
    typedef enum logic [1:0] {
        SRC_SEQ    = 2'd0,
        SRC_BRANCH = 2'd1,
        SRC_JUMP   = 2'd2
    } next_src_e;

endpackage

// File: rtl/pcu_select.sv
module pcu_select
    import pcu_pkg::*;
(
    input  logic      branch_req,
    input  logic      alu_zero,
    input  logic      jump_req,
    output next_src_e src
);

    // Jump outranks branch (R7); branch needs both request and zero (R5)
    always_comb begin
        if (jump_req)
            src = SRC_JUMP;
        else if (branch_req && alu_zero)
            src = SRC_BRANCH;
        else
            src = SRC_SEQ;
    end

endmodule

// File: rtl/pcu_target_calc.sv
module pcu_target_calc #(
    parameter int ADDR_W   = 32,
    parameter int IMM_W    = 16,
    parameter int JFIELD_W = 26
) (
    input  logic [ADDR_W-1:0]   pc,
    input  logic [IMM_W-1:0]    br_offset,
    input  logic [JFIELD_W-1:0] jump_field,
    output logic [ADDR_W-1:0]   seq_addr,
    output logic [ADDR_W-1:0]   branch_addr,
    output logic [ADDR_W-1:0]   jump_addr
);

    localparam int EXT_W    = ADDR_W - IMM_W - 2;
    localparam int REGION_W = ADDR_W - JFIELD_W - 2;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

    logic [ADDR_W-1:0] byte_offset;

    // Sequential address, wraps modulo 2^ADDR_W (R2, R9)
    assign seq_addr    = pc + STEP;

    // Word offset, sign-extended, scaled to bytes (R4)
    assign byte_offset = {{EXT_W{br_offset[IMM_W-1]}}, br_offset, 2'b00};
    assign branch_addr = seq_addr + byte_offset;

    // Region taken from the incremented address (R6, R9)
    assign jump_addr   = {seq_addr[ADDR_W-1 -: REGION_W], jump_field, 2'b00};

endmodule

// File: rtl/pcu_pc_reg.sv
module pcu_pc_reg #(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] next_pc,
    output logic [ADDR_W-1:0] pc
);

    // Written at every edge; no enable
    always_ff @(posedge clk) begin
        if (rst)
            pc <= RESET_VEC;
        else
            pc <= next_pc;
    end

    assert_aligned_R8: assert property (@(posedge clk) disable iff (rst)
        pc[1:0] == 2'b00)
        else $error("pc lost word alignment");

endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
    import pcu_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          IMM_W     = 16,
    parameter int          JFIELD_W  = 26,
    parameter logic [31:0] RESET_VEC = 32'h0000_0000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                branch_req,
    input  logic                alu_zero,
    input  logic                jump_req,
    input  logic [IMM_W-1:0]    br_offset,
    input  logic [JFIELD_W-1:0] jump_field,
    output logic [ADDR_W-1:0]   pc,
    output logic [ADDR_W-1:0]   pc_plus4
);

    localparam int EXT_W    = ADDR_W - IMM_W - 2;
    localparam int REGION_W = ADDR_W - JFIELD_W - 2;

    next_src_e         src;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] seq_addr;
    logic [ADDR_W-1:0] branch_addr;
    logic [ADDR_W-1:0] jump_addr;
    logic [ADDR_W-1:0] next_pc;

    pcu_select u_sel (
        .branch_req (branch_req),
        .alu_zero   (alu_zero),
        .jump_req   (jump_req),
        .src        (src)
    );

    pcu_target_calc #(
        .ADDR_W   (ADDR_W),
        .IMM_W    (IMM_W),
        .JFIELD_W (JFIELD_W)
    ) u_calc (
        .pc          (pc_q),
        .br_offset   (br_offset),
        .jump_field  (jump_field),
        .seq_addr    (seq_addr),
        .branch_addr (branch_addr),
        .jump_addr   (jump_addr)
    );

    // Next-address multiplexer
    always_comb begin
        unique case (src)
            SRC_BRANCH: next_pc = branch_addr;
            SRC_JUMP:   next_pc = jump_addr;
            default:    next_pc = seq_addr;
        endcase
    end

    pcu_pc_reg #(
        .ADDR_W    (ADDR_W),
        .RESET_VEC (ADDR_W'(RESET_VEC))
    ) u_reg (
        .clk     (clk),
        .rst     (rst),
        .next_pc (next_pc),
        .pc      (pc_q)
    );

    assign pc       = pc_q;
    assign pc_plus4 = seq_addr;

    // Transfer rules, checked against last cycle's address and inputs
    assert_seq_R3: assert property (@(posedge clk) disable iff (rst)
        (!jump_req && !branch_req) |=> pc_q == $past(pc_q) + ADDR_W'(4))
        else $error("sequential step wrong");

    assert_nobranch_R5: assert property (@(posedge clk) disable iff (rst)
        (!jump_req && (branch_req != alu_zero)) |=> pc_q == $past(pc_q) + ADDR_W'(4))
        else $error("half-qualified branch was taken");

    assert_branch_R4: assert property (@(posedge clk) disable iff (rst)
        (!jump_req && branch_req && alu_zero) |=>
        pc_q == $past(pc_q) + ADDR_W'(4)
                + {{EXT_W{$past(br_offset[IMM_W-1])}}, $past(br_offset), 2'b00})
        else $error("branch target wrong");

    assert_jump_R6: assert property (@(posedge clk) disable iff (rst)
        jump_req |=> pc_q[ADDR_W-REGION_W-1:0] == {$past(jump_field), 2'b00})
        else $error("jump field not loaded");

    assert_jump_priority_R7: assert property (@(posedge clk) disable iff (rst)
        (jump_req && branch_req && alu_zero) |=>
        pc_q[ADDR_W-1 -: REGION_W] == $past(pc_plus4[ADDR_W-1 -: REGION_W]))
        else $error("jump did not override branch");

endmodule

// File: tb/sim_pc_next_unit.sv
module sim_pc_next_unit;

    typedef struct packed {
        logic        br;
        logic        z;
        logic        jmp;
        logic [15:0] imm;
        logic [25:0] jf;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b0, 16'h0000, 26'h0000000},   // sequential
        '{1'b0, 1'b0, 1'b0, 16'h1234, 26'h3FFFFFF},   // sequential, junk fields
        '{1'b1, 1'b1, 1'b0, 16'h0003, 26'h0000000},   // branch taken
        '{1'b1, 1'b0, 1'b0, 16'h0007, 26'h0000000},   // branch, zero clear
        '{1'b0, 1'b1, 1'b0, 16'h0040, 26'h0000000},   // zero without branch
        '{1'b0, 1'b0, 1'b1, 16'h0000, 26'h0123456},   // jump
        '{1'b1, 1'b1, 1'b1, 16'h0010, 26'h0000040},   // jump beats branch
        '{1'b1, 1'b1, 1'b0, 16'hFFFE, 26'h0000000},   // negative offset
        '{1'b1, 1'b1, 1'b0, 16'h8000, 26'h0000000},   // most negative offset
        '{1'b0, 1'b0, 1'b1, 16'h0000, 26'h3FFFFFF}    // jump to top of region
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        branch_req = 1'b0;
    logic        alu_zero = 1'b0;
    logic        jump_req = 1'b0;
    logic [15:0] br_offset = '0;
    logic [25:0] jump_field = '0;
    logic [31:0] pc;
    logic [31:0] pc_plus4;

    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    logic [31:0] model_pc = 32'h0;

    always #10 clk = ~clk;   // 50 MHz

    pc_next_unit u0 (
        .clk        (clk),
        .rst        (rst),
        .branch_req (branch_req),
        .alu_zero   (alu_zero),
        .jump_req   (jump_req),
        .br_offset  (br_offset),
        .jump_field (jump_field),
        .pc         (pc),
        .pc_plus4   (pc_plus4)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Next address computed from the requirements
    function automatic logic [31:0] predict(input logic [31:0] cur, input logic b,
                                            input logic z, input logic j,
                                            input logic [15:0] imm, input logic [25:0] jf);
        logic [31:0] inc;
        inc = cur + 32'd4;
        if (j)
            return {inc[31:28], jf, 2'b00};
        else if (b && z)
            return inc + {{14{imm[15]}}, imm, 2'b00};
        else
            return inc;
    endfunction

    // Drive at negedge, let one rising edge pass, sample at the next negedge
    task automatic step(input string req, input logic b, input logic z, input logic j,
                        input logic [15:0] imm, input logic [25:0] jf);
        branch_req = b; alu_zero = z; jump_req = j; br_offset = imm; jump_field = jf;
        model_pc = predict(model_pc, b, z, j, imm, jf);
        @(posedge clk);
        @(negedge clk);
        check(req, "pc", pc, model_pc);
        check("R2", "pc_plus4", pc_plus4, model_pc + 32'd4);
        check("R8", "pc[1:0]", {30'd0, pc[1:0]}, 32'd0);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state, with a jump held on the inputs
        jump_req = 1'b1; jump_field = 26'h155_5555;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1", "pc after reset", pc, 32'h0);
        check("R2", "pc_plus4 after reset", pc_plus4, 32'h4);
        jump_req = 1'b0;
        rst = 1'b0;
        model_pc = 32'h0;

        // Vector table
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string tag;
            v = VECS[i];
            if (v.jmp && v.br && v.z)      tag = "R7";
            else if (v.jmp)                tag = "R6";
            else if (v.br && v.z)          tag = "R4";
            else if (v.br || v.z)          tag = "R5";
            else                           tag = "R3";
            step(tag, v.br, v.z, v.jmp, v.imm, v.jf);
        end

        // R9: the table leaves pc at 32'hFFFFFFFC; the next step wraps to 0
        check("R9", "pc at top of space", pc, 32'hFFFF_FFFC);
        step("R9", 1'b0, 1'b0, 1'b0, 16'h0, 26'h0);
        check("R9", "wrapped pc", pc, 32'h0);

        // R9: the region comes from pc+4 and crosses at 32'h0FFFFFFC
        step("R6", 1'b0, 1'b0, 1'b1, 16'h0, 26'h3FF_FFFF);
        check("R6", "top of region 0", pc, 32'h0FFF_FFFC);
        step("R9", 1'b0, 1'b0, 1'b1, 16'h0, 26'h000_0005);
        check("R9", "jump into region 1", pc, 32'h1000_0014);

        // R4: branch back to the same word (offset -1)
        step("R4", 1'b1, 1'b1, 1'b0, 16'hFFFF, 26'h0);
        check("R4", "branch to self", pc, 32'h1000_0014);

        // R1: reset mid-run wins over a taken jump
        @(negedge clk);
        rst = 1'b1; jump_req = 1'b1; jump_field = 26'h2AA_AAAA;
        @(posedge clk);
        @(negedge clk);
        check("R1", "pc after mid-run reset", pc, 32'h0);
        rst = 1'b0; jump_req = 1'b0;
        model_pc = 32'h0;
        step("R3", 1'b0, 1'b0, 1'b0, 16'h0, 26'h0);
        check("R3", "step after reset", pc, 32'h4);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule